// File: doc/BRIEF.md
# Programmable Frame Pattern Matcher

This block recognises received frames by comparing them against up to eight byte patterns at once. The patterns are not held in fixed comparators. They live as linked records in one shared 64-word by 40-bit table that the host loads. Two header words name where each pattern starts and which patterns are armed. Each following word carries four frame bytes and a control byte. The control byte says whether each byte is compared, whether the whole word is skipped, and whether the word closes the pattern.

Frame bytes arrive one per accepted beat on a valid/ready stream. Sideband flags mark the first and last byte. A beat is consumed only in a cycle where `s_valid` and `s_ready` are both high. The source must hold its data and flags stable while `s_ready` is low. `s_ready` drops for exactly the one cycle in which a frame result is presented, and is high at every other time. One cycle after the last byte is accepted, the block pulses `res_valid` and reports whether any armed pattern matched. When several matched, it reports the lowest-numbered one.

Top module: `pm_matcher`

## Requirements
- R1: After reset, `res_valid` is 0 and `s_ready` is 1. Every table word reads as zero, so no pattern is armed and no frame produces a hit.
- R2: When no frame is in progress, a host write with `wr_en` high stores `wr_data` at `wr_addr` at the clock edge.
- R3: Word 0 bits 7:0 are the arm bits, with bit i arming pattern i. Start addresses are the low 6 bits of byte lanes 1 to 4 (bits 15:8, 23:16, 31:24, 39:32). Word 0 holds patterns 0 to 3 in those lanes and word 1 holds patterns 4 to 7.
- R4: In a pattern word, bits 8k+15:8k+8 compare against frame byte 4n+k, where n is the word's position within the pattern. In the control byte, bit 7 ends the pattern, bit 6 skips the word, and bits 3:0 are compare enables, with bit k for byte lane k.
- R5: A byte lane whose compare enable is 0 accepts any frame byte.
- R6: A word with the skip bit set consumes four frame bytes without comparing any of them.
- R7: A pattern matches only if every compared byte agrees and all four bytes of its end word have arrived. A frame that ends earlier fails. Bytes after the end word are ignored. A pattern that reaches address 63 without an end word fails.
- R8: A pattern whose arm bit is 0 is never reported. When several patterns match, `res_id` is the lowest index among them.
- R9: Exactly one cycle after the end-of-frame beat is accepted, `res_valid` is 1 for one cycle, with `res_hit` and `res_id`, and `s_ready` is 0 in that cycle. Cycles with `s_valid` low inside a frame do not affect the result.
- R10: Host writes are ignored from the start-of-frame beat through the end-of-frame beat, inclusive.
- R11: Beats with `s_sof` low while no frame is in progress are ignored and produce no result. A start-of-frame beat inside a frame restarts the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Frame byte valid |
| s_ready | output | 1 | Block can take a frame byte |
| s_data | input | 8 | Frame byte |
| s_sof | input | 1 | Beat is the first byte of a frame |
| s_eof | input | 1 | Beat is the last byte of a frame |
| wr_en | input | 1 | Table write request |
| wr_addr | input | 6 | Table write address |
| wr_data | input | 40 | Table write word |
| res_valid | output | 1 | Frame result strobe |
| res_hit | output | 1 | Some armed pattern matched |
| res_id | output | 3 | Lowest matching pattern index |

## Verification
The bench builds the block with its default parameters: eight patterns and a 64-word table with 6-bit addresses. With these values, a pattern whose start pointer is 63 can be made to run off the end of the table, so the overflow failure can be exercised. The same table holds disabled, overlapping and catch-all patterns side by side, which brings the lowest-index priority and the arm bits within reach of one frame. Frames of three, four, seven and eight bytes test early termination inside both single-word and two-word patterns.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int BYTE_W   = 8;
  localparam int LANES    = 4;
  localparam int WORD_W   = BYTE_W * (LANES + 1);
  localparam int LANE_IW  = $clog2(LANES);

  typedef struct packed {
    logic       fin;
    logic       skip;
    logic [1:0] spare;
    logic [3:0] en;
  } ctrl_t;
endpackage

// File: rtl/pm_table.sv
module pm_table
  import pm_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NRD    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr [NRD],
  output logic [WORD_W-1:0] rd_data [NRD],
  output logic [WORD_W-1:0] hdr0,
  output logic [WORD_W-1:0] hdr1
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              we;

  assign we = wr_en && !lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (we) begin
      mem[wr_addr] <= wr_data;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = mem[rd_addr[g]];
  end

  assign hdr0 = mem[0];
  assign hdr1 = mem[1];

  // R10: a locked write leaves the addressed word untouched
  a_r10_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock) |=> (mem[$past(wr_addr)] == $past(mem[wr_addr])));
endmodule

// File: rtl/pm_track.sv
module pm_track
  import pm_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic [ADDR_W-1:0] ptr,
  input  logic              arm,
  input  logic [7:0]        fbyte,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_word,
  output logic              hit_nxt
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};
  localparam logic [LANE_IW-1:0] LANE_END = LANE_IW'(LANES - 1);

  logic [ADDR_W-1:0]  cur_q, e_cur, n_cur;
  logic [LANE_IW-1:0] idx_q, e_idx, n_idx;
  logic               alive_q, e_alive, n_alive;
  logic               done_q, e_done, n_done;
  ctrl_t              ctl;
  logic [7:0]         lane_b [LANES];
  logic               cmp_ok;

  assign e_cur   = start ? ptr : cur_q;
  assign e_idx   = start ? '0  : idx_q;
  assign e_alive = start ? arm : alive_q;
  assign e_done  = start ? 1'b0 : done_q;
  assign rd_addr = e_cur;
  assign ctl     = ctrl_t'(rd_word[7:0]);

  always_comb begin
    for (int k = 0; k < LANES; k++) lane_b[k] = rd_word[BYTE_W*(k+1) +: BYTE_W];
  end

  assign cmp_ok = ctl.skip || !ctl.en[e_idx] || (lane_b[e_idx] == fbyte);

  always_comb begin
    n_cur   = e_cur;
    n_idx   = e_idx;
    n_alive = e_alive;
    n_done  = e_done;
    if (e_alive && !e_done) begin
      if (!cmp_ok) n_alive = 1'b0;
      if (e_idx == LANE_END) begin
        n_idx = '0;
        if (ctl.fin)             n_done  = 1'b1;
        else if (e_cur == LAST)  n_alive = 1'b0;
        else                     n_cur   = e_cur + 1'b1;
      end else begin
        n_idx = e_idx + 1'b1;
      end
    end
  end

  assign hit_nxt = n_done && n_alive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      idx_q   <= '0;
      alive_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (step) begin
      cur_q   <= n_cur;
      idx_q   <= n_idx;
      alive_q <= n_alive;
      done_q  <= n_done;
    end
  end

  // R7: a failed pattern stays failed until the next frame start
  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!alive_q && !start) |=> !alive_q);
  // R7: once the end word completed, later bytes do not undo it
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start) |=> done_q);
endmodule

// File: rtl/pm_prio.sv
module pm_prio #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pm_matcher.sv
module pm_matcher
  import pm_pkg::*;
#(
  parameter int NUM_PAT = 8,
  parameter int ADDR_W  = 6,
  localparam int ID_W   = $clog2(NUM_PAT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  input  logic              s_sof,
  input  logic              s_eof,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              res_valid,
  output logic              res_hit,
  output logic [ID_W-1:0]   res_id
);
  logic                 beat, start, step, lock;
  logic                 in_frame_q, res_q;
  logic [NUM_PAT-1:0]   hit_nxt, hits_q, arm_q, arm_now;
  logic [ADDR_W-1:0]    rd_addr [NUM_PAT];
  logic [WORD_W-1:0]    rd_data [NUM_PAT];
  logic [WORD_W-1:0]    hdr0, hdr1;

  assign s_ready = !res_q;
  assign beat    = s_valid && s_ready;
  assign start   = beat && s_sof;
  assign step    = beat && (s_sof || in_frame_q);
  assign lock    = in_frame_q || start;
  assign arm_now = hdr0[NUM_PAT-1:0];

  pm_table #(.ADDR_W(ADDR_W), .NRD(NUM_PAT)) u_table (
    .clk(clk), .rst_n(rst_n), .lock(lock),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .hdr0(hdr0), .hdr1(hdr1)
  );

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    logic [WORD_W-1:0] hw;
    assign hw = (p < LANES) ? hdr0 : hdr1;
    pm_track #(.ADDR_W(ADDR_W)) u_track (
      .clk(clk), .rst_n(rst_n), .start(start), .step(step),
      .ptr(hw[BYTE_W*((p % LANES)+1) +: ADDR_W]),
      .arm(arm_now[p]), .fbyte(s_data),
      .rd_addr(rd_addr[p]), .rd_word(rd_data[p]), .hit_nxt(hit_nxt[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      res_q      <= 1'b0;
      hits_q     <= '0;
      arm_q      <= '0;
    end else begin
      res_q <= step && s_eof;
      if (step && s_eof)  hits_q <= hit_nxt;
      if (start)          arm_q  <= arm_now;
      if (step)           in_frame_q <= !s_eof;
    end
  end

  pm_prio #(.N(NUM_PAT), .IW(ID_W)) u_prio (
    .vec(hits_q), .found(res_hit), .idx(res_id)
  );

  assign res_valid = res_q;

  // R8: a reported pattern was armed when its frame started
  a_r8_armed_only: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> arm_q[res_id]);
  // R8: no lower-numbered pattern also matched
  a_r8_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((hits_q & ((NUM_PAT'(1) << res_id) - NUM_PAT'(1))) == '0));
  // R9: the result strobe lasts one cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
endmodule

// File: tb/test_pm_matcher.sv
`timescale 1ns/1ps
module test_pm_matcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_ready;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [39:0] wr_data = '0;
  logic        res_valid, res_hit;
  logic [2:0]  res_id;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  pm_matcher i_pm_matcher (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sof(s_sof), .s_eof(s_eof), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .res_valid(res_valid),
    .res_hit(res_hit), .res_id(res_id)
  );

  // {hit, id, len, bytes (byte 0 in bits 7:0)}
  localparam logic [103:0] VEC [9] = '{
    {1'b1, 3'd0, 4'd4, 96'h0_00000000_DDCCBBAA},  // R7 exact word
    {1'b1, 3'd2, 4'd4, 96'h0_00000000_0000BBAA},  // R5 masked lanes
    {1'b1, 3'd0, 4'd8, 96'h0_00330011_DDCCBBAA},  // R7 trailing bytes, R8 priority
    {1'b1, 3'd1, 4'd8, 96'h0_66335511_96979899},  // R6 skip word then masked word
    {1'b1, 3'd7, 4'd8, 96'h0_66345511_96979899},  // R4 lane 2 mismatch
    {1'b1, 3'd7, 4'd8, 96'h0_08070605_04030201},  // R7 runs past address 63
    {1'b0, 3'd0, 4'd3, 96'h0_00000000_00CCBBAA},  // R7 early end
    {1'b1, 3'd7, 4'd7, 96'h0_00335511_96979899},  // R7 early end in second word
    {1'b1, 3'd7, 4'd4, 96'h0_00000000_00000000}   // R8 disarmed pattern 4
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [5:0] a, input logic [39:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic beat(input logic [7:0] d, input bit sof, input bit eof);
    @(negedge clk); s_valid = 1'b1; s_data = d; s_sof = sof; s_eof = eof;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk); s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
  endtask

  task automatic expect_result(input bit hit, input logic [2:0] id, input string req);
    @(negedge clk); s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
    check(res_valid === 1'b1, {req, " res_valid"}, int'(res_valid), 1);
    check(s_ready === 1'b0, "R9 ready low", int'(s_ready), 0);
    check(res_hit === hit, {req, " res_hit"}, int'(res_hit), int'(hit));
    if (hit) check(res_id === id, {req, " res_id"}, int'(res_id), int'(id));
    @(negedge clk);
    check(res_valid === 1'b0, "R9 one-cycle pulse", int'(res_valid), 0);
  endtask

  task automatic send(input logic [95:0] d, input int len);
    for (int b = 0; b < len; b++) beat(d[8*b +: 8], b == 0, b == len - 1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid === 1'b0, "R1 res_valid", int'(res_valid), 0);
    check(s_ready === 1'b1, "R1 s_ready", int'(s_ready), 1);
    send(96'hDDCCBBAA, 4);
    expect_result(1'b0, 3'd0, "R1 empty table");

    // R3 headers: P0=2 P1=3 P2=5 P3=63, arm 0x8F; P4=6 P7=6
    host_write(6'd0, {8'h3F, 8'h05, 8'h03, 8'h02, 8'h8F});
    host_write(6'd1, {8'h06, 8'h00, 8'h00, 8'h06, 8'h00});
    host_write(6'd2, {8'hDD, 8'hCC, 8'hBB, 8'hAA, 8'h8F});
    host_write(6'd3, {32'h0, 8'h40});
    host_write(6'd4, {8'h44, 8'h33, 8'h22, 8'h11, 8'h85});
    host_write(6'd5, {8'hDD, 8'hCC, 8'hBB, 8'hAA, 8'h83});
    host_write(6'd6, {32'h0, 8'h80});
    host_write(6'd63, {8'h04, 8'h03, 8'h02, 8'h01, 8'h0F});

    for (int v = 0; v < 9; v++) begin
      send(VEC[v][95:0], int'(VEC[v][99:96]));
      expect_result(VEC[v][103], VEC[v][102:100], $sformatf("R7 vector %0d", v));
    end

    // R9: bubbles inside a frame
    beat(8'hAA, 1, 0); idle(); beat(8'hBB, 0, 0); idle(); idle();
    beat(8'hCC, 0, 0); beat(8'hDD, 0, 1);
    expect_result(1'b1, 3'd0, "R9 bubbles");

    // R10: writes during a frame are dropped, including on the sof beat
    @(negedge clk); s_valid = 1'b1; s_data = 8'hAA; s_sof = 1'b1; s_eof = 1'b0;
    wr_en = 1'b1; wr_addr = 6'd2; wr_data = '0;
    @(negedge clk); s_data = 8'hBB; s_sof = 1'b0; wr_addr = 6'd0;
    @(negedge clk); s_data = 8'hCC; wr_addr = 6'd5;
    @(negedge clk); s_data = 8'hDD; s_eof = 1'b1; wr_addr = 6'd1;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
    check(res_valid === 1'b1 && res_id === 3'd0, "R10 during frame", int'(res_id), 0);
    @(negedge clk);
    send(96'hDDCCBBAA, 4);
    expect_result(1'b1, 3'd0, "R10 table intact");

    // R11: stray beats outside a frame, then a restart inside a frame
    beat(8'h55, 0, 0); beat(8'h66, 0, 1); idle(); idle();
    check(res_valid === 1'b0, "R11 stray beats", int'(res_valid), 0);
    beat(8'h55, 1, 0); beat(8'hAA, 1, 0); beat(8'hBB, 0, 0);
    beat(8'hCC, 0, 0); beat(8'hDD, 0, 1);
    expect_result(1'b1, 3'd0, "R11 restart");

    // R2: rewrite pattern 0 word while idle
    host_write(6'd2, {8'h44, 8'h33, 8'h22, 8'h11, 8'h8F});
    send(96'h44332211, 4);
    expect_result(1'b1, 3'd0, "R2 rewrite");
    send(96'hDDCCBBAA, 4);
    expect_result(1'b1, 3'd2, "R2 old word gone");

    summary();
  end
endmodule